// File: doc/BRIEF.md
# PPP HDLC Receive Deframer

This block recovers PPP frames from an octet-synchronous receive stream. Input bytes arrive on a valid/ready port. The block hunts for the 0x7E flag and throws away the idle fill between frames. It undoes the 0x7D escape stuffing and detects frames that a sender has aborted. It checks the frame check sequence with either CRC-16 (CCITT) or CRC-32, chosen at run time. Each frame is delivered on an 8-bit valid/ready packet port with start, end and error marks. A frame with a bad FCS, a runt or an aborted frame is still delivered, and its last delivered byte carries the error mark.

At the closing flag of every frame, one of four single-cycle event pulses fires for the statistics logic: good, FCS error, abort or runt. An optional mode removes the FCS octets before delivery. Back-pressure works by stalling the whole block: when the output register is full and `out_ready` is low, `in_ready` drops, and no input byte is taken until the held output byte leaves.

`crc32_sel` and `fcs_del` must only change while `en` is low or between frames. Pulling `en` low empties the block, and afterwards it needs a new flag before it accepts a frame.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Input bytes taken before the first flag after reset or enable produce no output and no event. A run of consecutive flags between frames produces no output and no event.
- R2: Inside a frame, the byte 0x7D is removed, and the byte that follows it is delivered XORed with 0x20 (so 0x7D 0x5E gives 0x7E and 0x7D 0x5D gives 0x7D).
- R3: With `crc32_sel`=0, the FCS is CRC-16 with polynomial x^16+x^12+x^5+1, preset to all ones, bits taken LSB first. A frame whose CRC over data plus FCS leaves the residue 0xF0B8 is delivered with `out_err`=0, and `ev_good` pulses.
- R4: With `crc32_sel`=1, the FCS is the standard CRC-32, preset to all ones, LSB first, with good residue 0xDEBB20E3. A good frame is delivered with `out_err`=0, and `ev_good` pulses.
- R5: A frame of runt length or more whose residue is wrong is still delivered. `out_err` is set on its last byte and `ev_fcs_err` pulses.
- R6: The sequence 0x7D 0x7E inside a frame aborts it. `ev_abort` pulses, and any part already started on the output is closed with `out_eop` and `out_err`. The 0x7E also serves as the opening flag of the next frame.
- R7: A frame of fewer than 3 octets (CRC-16) or 5 octets (CRC-32), counted after destuffing, pulses `ev_runt` and not `ev_fcs_err`. A frame of exactly 3 or 5 octets is judged by its FCS.
- R8: With `fcs_del`=1, the last 2 (CRC-16) or 4 (CRC-32) octets of a frame are not delivered. With `fcs_del`=0, every octet is delivered. A runt in delete mode delivers nothing.
- R9: Each frame end produces exactly one event pulse, and at most one event output is high in any cycle.
- R10: While `out_valid`=1 and `out_ready`=0, the output byte and its marks hold steady, `in_ready` is 0, and no data is lost.
- R11: While `en`=0, `in_ready` and `out_valid` are 0. A frame that `en` interrupts produces no event, and after `en` returns the block waits for a flag.
- R12: After reset, `out_valid` and all event outputs are 0 and `in_ready` equals `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; when low, all state returns to flag hunt |
| crc32_sel | input | 1 | 0: CRC-16 FCS, 1: CRC-32 FCS |
| fcs_del | input | 1 | 1: remove FCS octets from delivered frames |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Received line octet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts output byte |
| out_data | output | 8 | Delivered frame octet |
| out_sop | output | 1 | First delivered octet of a frame |
| out_eop | output | 1 | Last delivered octet of a frame |
| out_err | output | 1 | Frame was not good (set with out_eop) |
| ev_good | output | 1 | One-cycle pulse: good frame |
| ev_fcs_err | output | 1 | One-cycle pulse: FCS error |
| ev_abort | output | 1 | One-cycle pulse: aborted frame |
| ev_runt | output | 1 | One-cycle pulse: runt frame |

## Verification
The hardest cases to reach from the ports are the runt boundary and a stall at frame end. For the runt boundary, escape stuffing makes the line length differ from the counted octet length. The stimulus sends a fully escaped two-octet frame that takes four line bytes. It also sends frames of exactly 3 and 5 octets that carry a correct FCS. For the stall, `out_ready` is toggled in a fixed pattern while a long CRC-32 frame streams in, so that the closing flag and the last data bytes meet a full output register. A separate sequence drops `en` in the middle of a frame and then sends non-flag bytes, to show that the block returns to flag hunting.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [7:0]  FLAG_B = 8'h7E;
  localparam logic [7:0]  ESC_B  = 8'h7D;
  localparam logic [7:0]  FLIP_B = 8'h20;
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [31:0] POLY16 = 32'h00008408;
  localparam logic [31:0] INIT32 = 32'hFFFFFFFF;
  localparam logic [31:0] INIT16 = 32'h0000FFFF;
  localparam logic [31:0] RES32  = 32'hDEBB20E3;
  localparam logic [15:0] RES16  = 16'hF0B8;

  typedef enum logic [1:0] {ST_SEEK, ST_IDLE, ST_DATA, ST_ESC} rx_st_e;

  // Reflected (LSB-first) CRC update by one octet
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in,
                                           input logic [7:0]  d,
                                           input logic        wide);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ (wide ? POLY32 : POLY16);
    end
    return c;
  endfunction
endpackage

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic       first,
  input  logic       wide,
  input  logic [7:0] din,
  output logic       match
);
  logic [31:0] crc_q;
  logic [31:0] base;

  always_comb base = first ? (wide ? INIT32 : INIT16) : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= INIT32;
    else if (clr)   crc_q <= INIT32;
    else if (upd)   crc_q <= crc_byte(base, din, wide);
  end

  always_comb match = wide ? (crc_q == RES32) : (crc_q[15:0] == RES16);
endmodule

// File: rtl/hdlc_rx_hold.sv
module hdlc_rx_hold #(
  parameter int DEPTH = 5,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       tap
);
  logic [7:0] sh [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh[g] <= '0;
      else if (push) sh[g] <= (g == 0) ? din : sh[(g == 0) ? 0 : g - 1];
    end
  end

  always_comb begin
    tap = '0;
    for (int i = 0; i < DEPTH; i++)
      if (idx == IDX_W'(i)) tap = sh[i];
  end
endmodule

// File: rtl/hdlc_rx_oreg.sv
module hdlc_rx_oreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] d,
  input  logic       sop,
  input  logic       eop,
  input  logic       err,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] q,
  output logic       q_sop,
  output logic       q_eop,
  output logic       q_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
      q_sop <= 1'b0;
      q_eop <= 1'b0;
      q_err <= 1'b0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
      q_sop <= sop;
      q_eop <= eop;
      q_err <= err;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !clr |=> valid && $stable(q) && $stable(q_eop) && $stable(q_err));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int HOLD_DEPTH = 5,
  parameter int CNT_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       crc32_sel,
  input  logic       fcs_del,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       out_err,
  output logic       ev_good,
  output logic       ev_fcs_err,
  output logic       ev_abort,
  output logic       ev_runt
);
  localparam int IDX_W = $clog2(HOLD_DEPTH);

  rx_st_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, fcs_len, hold_n, runt_min;
  logic             fire, is_flag, is_esc, dat_push, close_f, abort_f, end_any;
  logic             runt, crc_ok, emit_push, emit_end, emit_sop;
  logic [7:0]       dat_val, tap;
  logic [IDX_W-1:0] tap_idx;

  always_comb begin
    in_ready = en && (!out_valid || out_ready);
    fire     = in_valid && in_ready;
    is_flag  = (in_data == FLAG_B);
    is_esc   = (in_data == ESC_B);
    fcs_len  = crc32_sel ? CNT_W'(4) : CNT_W'(2);
    runt_min = fcs_len + CNT_W'(1);
    hold_n   = fcs_del ? runt_min : CNT_W'(1);
    tap_idx  = IDX_W'(hold_n - CNT_W'(1));
    dat_val  = (st_q == ST_ESC) ? (in_data ^ FLIP_B) : in_data;
    dat_push = fire && !is_flag &&
               (((st_q == ST_IDLE || st_q == ST_DATA) && !is_esc) || st_q == ST_ESC);
    close_f  = fire && is_flag && (st_q == ST_DATA);
    abort_f  = fire && is_flag && (st_q == ST_ESC);
    end_any  = close_f || abort_f;
    runt     = cnt_q < runt_min;
    emit_push = dat_push && (cnt_q >= hold_n);
    emit_end  = end_any && (cnt_q >= hold_n);
    emit_sop  = (cnt_q == hold_n);
  end

  always_comb begin
    st_d = st_q;
    if (fire) begin
      unique case (st_q)
        ST_SEEK: if (is_flag) st_d = ST_IDLE;
        ST_IDLE, ST_DATA: st_d = is_flag ? ST_IDLE : (is_esc ? ST_ESC : ST_DATA);
        ST_ESC:  st_d = is_flag ? ST_IDLE : ST_DATA;
        default: st_d = ST_SEEK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SEEK;
      cnt_q <= '0;
      {ev_good, ev_fcs_err, ev_abort, ev_runt} <= '0;
    end else if (!en) begin
      st_q  <= ST_SEEK;
      cnt_q <= '0;
      {ev_good, ev_fcs_err, ev_abort, ev_runt} <= '0;
    end else begin
      st_q <= st_d;
      if (end_any)                       cnt_q <= '0;
      else if (dat_push && cnt_q != '1)  cnt_q <= cnt_q + CNT_W'(1);
      ev_good    <= close_f && !runt && crc_ok;
      ev_fcs_err <= close_f && !runt && !crc_ok;
      ev_runt    <= close_f && runt;
      ev_abort   <= abort_f;
    end
  end

  hdlc_rx_fcs u_fcs (
    .clk(clk), .rst_n(rst_n), .clr(!en), .upd(dat_push),
    .first(cnt_q == '0), .wide(crc32_sel), .din(dat_val), .match(crc_ok)
  );

  hdlc_rx_hold #(.DEPTH(HOLD_DEPTH), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(dat_push), .din(dat_val), .idx(tap_idx), .tap(tap)
  );

  hdlc_rx_oreg u_oreg (
    .clk(clk), .rst_n(rst_n), .clr(!en), .load(emit_push || emit_end),
    .d(tap), .sop(emit_sop), .eop(emit_end),
    .err(emit_end && (abort_f || runt || !crc_ok)), .ready(out_ready),
    .valid(out_valid), .q(out_data), .q_sop(out_sop), .q_eop(out_eop), .q_err(out_err)
  );

  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_good, ev_fcs_err, ev_abort, ev_runt}));

  // R3
  good_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_good |-> out_valid && out_eop && !out_err);

  // R5
  fcs_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fcs_err |-> out_valid && out_eop && out_err);

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == ST_SEEK) && !out_valid);
endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic       crc32_sel = 1'b0, fcs_del = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_sop, out_eop, out_err;
  logic [7:0] out_data;
  logic       ev_good, ev_fcs_err, ev_abort, ev_runt;

  hdlc_rx_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .crc32_sel(crc32_sel), .fcs_del(fcs_del),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
    .ev_good(ev_good), .ev_fcs_err(ev_fcs_err), .ev_abort(ev_abort), .ev_runt(ev_runt)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] cap_d[$];
  bit cap_sop[$], cap_eop[$], cap_err[$];
  int e_good = 0, e_fcs = 0, e_abort = 0, e_runt = 0;
  bit stall_seen = 0, bp_on = 0;
  int bp_ctr = 0;
  logic [7:0] exp_frame[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        cap_d.push_back(out_data); cap_sop.push_back(out_sop);
        cap_eop.push_back(out_eop); cap_err.push_back(out_err);
      end
      if (ev_good) e_good++;
      if (ev_fcs_err) e_fcs++;
      if (ev_abort) e_abort++;
      if (ev_runt) e_runt++;
    end
  end

  always @(posedge clk) begin
    #2;
    if (bp_on) begin bp_ctr++; out_ready = (bp_ctr % 3) != 0; end
    else out_ready = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input logic [7:0] q[$], input bit w);
    logic [31:0] c;
    c = w ? 32'hFFFFFFFF : 32'h0000FFFF;
    foreach (q[k]) begin
      c = c ^ {24'h0, q[k]};
      for (int b = 0; b < 8; b++)
        c = c[0] ? ((c >> 1) ^ (w ? 32'hEDB88320 : 32'h00008408)) : (c >> 1);
    end
    return ~c & (w ? 32'hFFFFFFFF : 32'h0000FFFF);
  endfunction

  task automatic clear_cap();
    cap_d.delete(); cap_sop.delete(); cap_eop.delete(); cap_err.delete();
    e_good = 0; e_fcs = 0; e_abort = 0; e_runt = 0; stall_seen = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) begin stall_seen = 1; @(negedge clk); end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] pl[$], input bit w, input bit bad);
    logic [31:0] f;
    logic [7:0] fr[$];
    fr = pl;
    f = crc_ref(pl, w);
    if (bad) f = f ^ 32'h1;
    for (int i = 0; i < (w ? 4 : 2); i++) fr.push_back(f[8*i +: 8]);
    exp_frame = fr;
    foreach (fr[k]) begin
      if (fr[k] == 8'h7E || fr[k] == 8'h7D) begin push(8'h7D); push(fr[k] ^ 8'h20); end
      else push(fr[k]);
    end
    push(8'h7E);
  endtask

  task automatic expect_pkt(input string req, input logic [7:0] exp[$], input bit err);
    repeat (3) @(negedge clk);
    chk({req, " length"}, cap_d.size(), exp.size());
    if (cap_d.size() == exp.size()) begin
      foreach (exp[k]) begin
        chk({req, " data"}, cap_d[k], exp[k]);
        chk({req, " sop"}, cap_sop[k], k == 0);
        chk({req, " eop"}, cap_eop[k], k == exp.size() - 1);
        chk({req, " err"}, cap_err[k], (k == exp.size() - 1) ? err : 1'b0);
      end
    end
  endtask

  task automatic expect_ev(input string req, input int g, input int f, input int a, input int r);
    chk({req, " good count"}, e_good, g);
    chk({req, " fcs count"}, e_fcs, f);
    chk({req, " abort count"}, e_abort, a);
    chk({req, " runt count"}, e_runt, r);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 out_valid", out_valid, 0);
    chk("R12 in_ready", in_ready, 1);
    chk("R12 events", {ev_good, ev_fcs_err, ev_abort, ev_runt}, 0);
  endtask

  task automatic t_crc_model();
    logic [7:0] q[$];
    for (int i = 0; i < 9; i++) q.push_back(8'h31 + 8'(i));
    chk("R3 bench crc16 model", crc_ref(q, 0), 32'h906E);
    chk("R4 bench crc32 model", crc_ref(q, 1), 32'hCBF43926);
  endtask

  task automatic t_fill_stuff();
    logic [7:0] pl[$];
    clear_cap(); crc32_sel = 0; fcs_del = 0;
    push(8'h11); push(8'h7D); push(8'h22);
    push(8'h7E); push(8'h7E); push(8'h7E);
    repeat (3) @(negedge clk);
    chk("R1 fill output", cap_d.size(), 0);
    expect_ev("R1", 0, 0, 0, 0);
    pl = {8'h7E, 8'h41, 8'h7D};
    send_frame(pl, 0, 0);
    expect_pkt("R2 R3 crc16 stuffed", exp_frame, 0);
    expect_ev("R3 R9", 1, 0, 0, 0);
  endtask

  task automatic t_crc32_del();
    logic [7:0] pl[$];
    clear_cap(); crc32_sel = 1; fcs_del = 1;
    pl = {8'hA5, 8'h00, 8'hFF, 8'h7D, 8'h13};
    send_frame(pl, 1, 0);
    expect_pkt("R4 R8 crc32 delete", pl, 0);
    expect_ev("R4 R9", 1, 0, 0, 0);
  endtask

  task automatic t_crc16_del();
    logic [7:0] pl[$];
    clear_cap(); crc32_sel = 0; fcs_del = 1;
    pl = {8'h5A};
    send_frame(pl, 0, 0);
    expect_pkt("R8 R7 crc16 delete 3 octets", pl, 0);
    expect_ev("R7 boundary 3", 1, 0, 0, 0);
  endtask

  task automatic t_fcs_err();
    logic [7:0] pl[$];
    clear_cap(); crc32_sel = 1; fcs_del = 0;
    pl = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    send_frame(pl, 1, 1);
    expect_pkt("R5 bad fcs", exp_frame, 1);
    expect_ev("R5 R9", 0, 1, 0, 0);
  endtask

  task automatic t_abort();
    logic [7:0] pl[$], ab[$];
    clear_cap(); crc32_sel = 0; fcs_del = 0;
    push(8'h01); push(8'h02); push(8'h03); push(8'h7D); push(8'h7E);
    ab = {8'h01, 8'h02, 8'h03};
    expect_pkt("R6 abort", ab, 1);
    expect_ev("R6 R9", 0, 0, 1, 0);
    clear_cap();
    pl = {8'h99, 8'h88};
    send_frame(pl, 0, 0);
    expect_pkt("R6 frame after abort", exp_frame, 0);
    expect_ev("R6 after", 1, 0, 0, 0);
  endtask

  task automatic t_runt();
    logic [7:0] ex[$], pl[$];
    clear_cap(); crc32_sel = 0; fcs_del = 0;
    push(8'h7D); push(8'h5E); push(8'h7D); push(8'h5D); push(8'h7E);
    ex = {8'h7E, 8'h7D};
    expect_pkt("R7 crc16 runt", ex, 1);
    expect_ev("R7 crc16", 0, 0, 0, 1);
    clear_cap(); crc32_sel = 1; fcs_del = 1;
    push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h7E);
    repeat (3) @(negedge clk);
    chk("R7 R8 crc32 runt delete output", cap_d.size(), 0);
    expect_ev("R7 crc32", 0, 0, 0, 1);
    clear_cap();
    pl = {8'hC3};
    send_frame(pl, 1, 0);
    expect_pkt("R7 crc32 boundary 5 octets", pl, 0);
    expect_ev("R7 boundary 5", 1, 0, 0, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] pl[$];
    clear_cap(); crc32_sel = 1; fcs_del = 0;
    for (int i = 0; i < 10; i++) pl.push_back(8'(8'h30 + 8'(i * 7)));
    bp_on = 1;
    send_frame(pl, 1, 0);
    bp_on = 0;
    chk("R10 stall seen", stall_seen, 1);
    expect_pkt("R10 backpressure", exp_frame, 0);
    expect_ev("R10", 1, 0, 0, 0);
  endtask

  task automatic t_enable();
    logic [7:0] pl[$];
    clear_cap(); crc32_sel = 0; fcs_del = 0;
    push(8'h01); push(8'h02); push(8'h03);
    @(negedge clk); en = 0;
    @(negedge clk);
    chk("R11 in_ready low", in_ready, 0);
    chk("R11 out_valid low", out_valid, 0);
    en = 1;
    @(negedge clk);
    clear_cap();
    push(8'h55); push(8'h66);
    repeat (3) @(negedge clk);
    chk("R11 hunt output", cap_d.size(), 0);
    expect_ev("R11 hunt", 0, 0, 0, 0);
    push(8'h7E);
    pl = {8'h12, 8'h34, 8'h56};
    send_frame(pl, 0, 0);
    expect_pkt("R11 after enable", exp_frame, 0);
    expect_ev("R11 after", 1, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_crc_model();
    t_fill_stuff();
    t_crc32_del();
    t_crc16_del();
    t_fcs_err();
    t_abort();
    t_runt();
    t_backpressure();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule